// File: doc/BRIEF.md
# Floating-Point Sign and Classify Unit

This block performs the floating-point operations that need no rounding and raise no exception flag: absolute value, negate, copy-sign and classify. It handles both single and double precision. Operands and results sit in 64-bit register slots. A single-precision value lives in the low 32 bits of its slot.

Each request presents an opcode, a precision select and two 64-bit operands, called fj and fk, together with a valid strobe. The result appears one clock later on a registered output with its own valid flag. Single-precision sign results are NaN-boxed: the upper half of the slot is forced to ones. Classify instead returns a ten-bit one-hot category mask, zero-extended to 64 bits.

Top module: `fpsc_unit`

## Requirements
- R1: `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and low otherwise. After reset `out_valid` is 0 and `out_result` is 0.
- R2: Opcode 0 (absolute value) clears the sign bit and passes every other bit of fj unchanged. The sign bit is bit 31 when `in_dbl`=0 (single) and bit 63 when `in_dbl`=1 (double).
- R3: Opcode 1 (negate) inverts the sign bit (bit 31 single, bit 63 double) and passes every other bit of fj unchanged.
- R4: Opcode 2 (copy-sign) returns the non-sign bits of fj together with the sign bit of fk (bit 31 single, bit 63 double).
- R5: For opcodes 0, 1 and 2 in single precision, `out_result[63:32]` is all ones.
- R6: A single-precision operation uses only bits [31:0] of fj and fk. Their upper halves have no effect on the result.
- R7: Opcode 3 (classify) sets exactly one bit of `out_result[9:0]`. The bit assignment is: 0 signaling NaN, 1 quiet NaN, 2 negative infinity, 3 negative normal, 4 negative subnormal, 5 negative zero, 6 positive infinity, 7 positive normal, 8 positive subnormal, 9 positive zero. The field widths are an 8-bit exponent and 23-bit fraction for single precision, and an 11-bit exponent and 52-bit fraction for double precision.
- R8: The classify result is zero-extended: `out_result[63:10]` is 0 in both precisions.
- R9: For a NaN, the class ignores the sign bit. The NaN is quiet when the top fraction bit is 1 and signaling when it is 0.
- R10: While `in_valid` is low, `out_result` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | 0 abs, 1 negate, 2 copy-sign, 3 classify |
| in_dbl | input | 1 | 0 single precision, 1 double precision |
| in_fj | input | 64 | First operand slot |
| in_fk | input | 64 | Second operand slot (sign source for copy-sign) |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_result | output | 64 | Registered result |

## Verification
Random operands are biased toward all-ones and all-zero exponents and zero fractions, so that every classify category is reached. This separates infinity from NaN, zero from subnormal, and quiet from signaling NaN in both precisions. Directed cases add:
- NaNs of both signs, which show whether the sign leaks into the NaN class;
- single-precision operands with differing garbage in the upper half, which expose any read of bits [63:32];
- sign operations on both signs, which show whether only the sign bit moves.

Idle cycles with changing operands separate a result that holds from one that follows its inputs.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;

   typedef enum logic [1:0] {
      OP_ABS   = 2'd0,
      OP_NEG   = 2'd1,
      OP_CSGN  = 2'd2,
      OP_CLASS = 2'd3
   } fpsc_op_e;

   localparam int CLASS_W   = 10;
   localparam int CB_SNAN   = 0;
   localparam int CB_QNAN   = 1;
   localparam int CB_NINF   = 2;
   localparam int CB_NNORM  = 3;
   localparam int CB_NSUB   = 4;
   localparam int CB_NZERO  = 5;
   localparam int CB_PINF   = 6;
   localparam int CB_PNORM  = 7;
   localparam int CB_PSUB   = 8;
   localparam int CB_PZERO  = 9;

endpackage

// File: rtl/fpsc_class_fmt.sv
module fpsc_class_fmt
   import fpsc_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int VAL_W = 1 + EXP_W + MAN_W
) (
   input  logic [VAL_W-1:0]   val,
   output logic [CLASS_W-1:0] mask
);

   logic             sgn;
   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic             exp_max, exp_min, man_nil;

   assign sgn     = val[VAL_W-1];
   assign exp_f   = val[VAL_W-2:MAN_W];
   assign man_f   = val[MAN_W-1:0];
   assign exp_max = &exp_f;
   assign exp_min = ~|exp_f;
   assign man_nil = ~|man_f;

   // infinity, then zero, then subnormal, then NaN, else normal
   always_comb begin
      mask = '0;
      if (exp_max && man_nil)
         mask[sgn ? CB_NINF : CB_PINF] = 1'b1;
      else if (exp_min && man_nil)
         mask[sgn ? CB_NZERO : CB_PZERO] = 1'b1;
      else if (exp_min)
         mask[sgn ? CB_NSUB : CB_PSUB] = 1'b1;
      else if (exp_max)
         mask[man_f[MAN_W-1] ? CB_QNAN : CB_SNAN] = 1'b1;
      else
         mask[sgn ? CB_NNORM : CB_PNORM] = 1'b1;
   end

endmodule

// File: rtl/fpsc_sign_fmt.sv
module fpsc_sign_fmt
   import fpsc_pkg::*;
#(
   parameter int W = 32
) (
   input  fpsc_op_e       op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [W-1:0]   y
);

   logic [W-2:0] mag;
   assign mag = a[W-2:0];

   always_comb begin
      unique case (op)
         OP_ABS:  y = {1'b0, mag};
         OP_NEG:  y = {~a[W-1], mag};
         OP_CSGN: y = {b[W-1], mag};
         default: y = a;
      endcase
   end

endmodule

// File: rtl/fpsc_unit.sv
module fpsc_unit
   import fpsc_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int SP_EXP_W = 8,
   parameter int SP_MAN_W = 23,
   parameter int DP_EXP_W = 11,
   parameter int DP_MAN_W = 52,
   parameter bit NANBOX   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        in_op,
   input  logic              in_dbl,
   input  logic [DATA_W-1:0] in_fj,
   input  logic [DATA_W-1:0] in_fk,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result
);

   localparam int SP_W  = 1 + SP_EXP_W + SP_MAN_W;
   localparam int DP_W  = 1 + DP_EXP_W + DP_MAN_W;
   localparam int BOX_W = DATA_W - SP_W;
   localparam int PAD_W = DATA_W - CLASS_W;

   generate
      if (DP_W != DATA_W) begin : g_chk_dp
         $error("double format must fill the slot");
      end
      if (SP_W >= DATA_W) begin : g_chk_sp
         $error("single format must be narrower than the slot");
      end
      if (CLASS_W > DATA_W) begin : g_chk_cls
         $error("class mask wider than slot");
      end
   endgenerate

   fpsc_op_e op_c;
   assign op_c = fpsc_op_e'(in_op);

   logic [SP_W-1:0]    sp_y;
   logic [DP_W-1:0]    dp_y;
   logic [CLASS_W-1:0] sp_cls, dp_cls;
   logic [BOX_W-1:0]   box_fill;

   fpsc_sign_fmt #(.W(SP_W)) u_sp_sign (
      .op (op_c), .a (in_fj[SP_W-1:0]), .b (in_fk[SP_W-1:0]), .y (sp_y)
   );
   fpsc_sign_fmt #(.W(DP_W)) u_dp_sign (
      .op (op_c), .a (in_fj[DP_W-1:0]), .b (in_fk[DP_W-1:0]), .y (dp_y)
   );
   fpsc_class_fmt #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) u_sp_class (
      .val (in_fj[SP_W-1:0]), .mask (sp_cls)
   );
   fpsc_class_fmt #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W)) u_dp_class (
      .val (in_fj[DP_W-1:0]), .mask (dp_cls)
   );

   generate
      if (NANBOX) begin : g_box_ones
         assign box_fill = '1;
      end else begin : g_box_zero
         assign box_fill = '0;
      end
   endgenerate

   logic [DATA_W-1:0] nxt_result;
   always_comb begin
      if (op_c == OP_CLASS)
         nxt_result = {{PAD_W{1'b0}}, (in_dbl ? dp_cls : sp_cls)};
      else if (in_dbl)
         nxt_result = dp_y;
      else
         nxt_result = {box_fill, sp_y};
   end

   fpsc_op_e r_op;
   logic     r_dbl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
         r_op       <= OP_ABS;
         r_dbl      <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result <= nxt_result;
            r_op       <= op_c;
            r_dbl      <= in_dbl;
         end
      end
   end

   // R1: valid follows the request by one cycle
   a_r1_valid_lat: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   // R10: idle cycles leave the result untouched
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_result));

   // R2: double abs clears sign, keeps magnitude
   a_r2_abs_dp: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && r_op == OP_ABS && r_dbl) |->
      (!out_result[DATA_W-1] && out_result[DATA_W-2:0] == $past(in_fj[DATA_W-2:0])));

   // R3: double negate flips only the sign
   a_r3_neg_dp: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && r_op == OP_NEG && r_dbl) |->
      (out_result == ($past(in_fj) ^ {1'b1, {(DATA_W-1){1'b0}}})));

   // R4: copy-sign takes sign from fk
   a_r4_csgn_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && r_op == OP_CSGN) |->
      (r_dbl ? out_result[DATA_W-1] == $past(in_fk[DATA_W-1])
             : out_result[SP_W-1] == $past(in_fk[SP_W-1])));

   // R7, R8: one-hot class, zero-extended
   a_r8_class_shape: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && r_op == OP_CLASS) |->
      (out_result[DATA_W-1:CLASS_W] == '0 && $countones(out_result[CLASS_W-1:0]) == 1));

   generate
      if (NANBOX) begin : g_box_chk
         // R5: single sign results are boxed
         a_r5_nanbox: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && r_op != OP_CLASS && !r_dbl) |-> (&out_result[DATA_W-1:SP_W]));
      end
   endgenerate

endmodule

// File: tb/fpsc_unit_bench.sv
module fpsc_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [1:0]  in_op;
   logic        in_dbl;
   logic [63:0] in_fj, in_fk;
   logic        out_valid;
   logic [63:0] out_result;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   fpsc_unit u_fpsc_unit (
      .clk, .rst_n, .in_valid, .in_op, .in_dbl, .in_fj, .in_fk,
      .out_valid, .out_result
   );

   function automatic logic [9:0] exp_class(logic [63:0] v, bit dbl);
      bit s, eo, ez, mz, q;
      if (dbl) begin
         s = v[63]; eo = &v[62:52]; ez = ~|v[62:52]; mz = ~|v[51:0]; q = v[51];
      end else begin
         s = v[31]; eo = &v[30:23]; ez = ~|v[30:23]; mz = ~|v[22:0]; q = v[22];
      end
      if (eo && mz)      return s ? 10'h004 : 10'h040;
      else if (ez && mz) return s ? 10'h020 : 10'h200;
      else if (ez)       return s ? 10'h010 : 10'h100;
      else if (eo)       return q ? 10'h002 : 10'h001;
      else               return s ? 10'h008 : 10'h080;
   endfunction

   function automatic logic [63:0] exp_result(logic [1:0] op, bit dbl,
                                              logic [63:0] a, logic [63:0] b);
      logic [63:0] r;
      if (op == 2'd3) return {54'd0, exp_class(a, dbl)};
      if (dbl) begin
         r = a;
         if (op == 2'd0) r[63] = 1'b0;
         else if (op == 2'd1) r[63] = ~a[63];
         else r[63] = b[63];
      end else begin
         r = {32'hFFFF_FFFF, a[31:0]};
         if (op == 2'd0) r[31] = 1'b0;
         else if (op == 2'd1) r[31] = ~a[31];
         else r[31] = b[31];
      end
      return r;
   endfunction

   function automatic string tag_of(logic [1:0] op, bit dbl);
      case (op)
         2'd0: return dbl ? "R2" : "R2/R5/R6";
         2'd1: return dbl ? "R3" : "R3/R5/R6";
         2'd2: return dbl ? "R4" : "R4/R5/R6";
         default: return "R7/R8/R9";
      endcase
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_op(logic [1:0] op, bit dbl, logic [63:0] a, logic [63:0] b,
                        string tag);
      @(negedge clk);
      in_op = op; in_dbl = dbl; in_fj = a; in_fk = b; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R1 valid", {63'd0, out_valid}, 64'd1);
      check(tag, out_result, exp_result(op, dbl, a, b));
   endtask

   function automatic logic [63:0] rnd_val();
      logic [63:0] v = {$urandom, $urandom};
      case ($urandom % 7)
         0: v[62:52] = '1;
         1: v[62:52] = '0;
         2: v[30:23] = '1;
         3: v[30:23] = '0;
         4: begin v[62:52] = '1; v[51:0] = '0; v[30:23] = '1; v[22:0] = '0; end
         5: begin v[62:52] = '0; v[51:0] = '0; v[30:23] = '0; v[22:0] = '0; end
         default: ;
      endcase
      return v;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] held;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; in_valid = 1'b0; in_op = 2'd0; in_dbl = 1'b0;
      in_fj = '0; in_fk = '0;
      repeat (3) @(negedge clk);
      check("R1 reset valid", {63'd0, out_valid}, 64'd0);
      check("R1 reset result", out_result, 64'd0);
      rst_n = 1'b1;

      // directed sign operations, both signs
      do_op(2'd0, 1, 64'hC00F_0000_1234_5678, 64'd0, "R2 abs dp");
      do_op(2'd0, 0, 64'h1234_5678_BF80_0001, 64'd0, "R2 abs sp");
      do_op(2'd1, 1, 64'h4000_0000_0000_0001, 64'd0, "R3 neg dp");
      do_op(2'd1, 0, 64'h0000_0000_7F80_0000, 64'd0, "R3 neg sp");
      do_op(2'd2, 1, 64'h3FF0_0000_0000_0000, 64'h8000_0000_0000_0000, "R4 csgn dp");
      do_op(2'd2, 0, 64'h0000_0000_C000_0000, 64'hFFFF_FFFF_0000_0000, "R4 csgn sp");
      // R6: upper garbage must not matter
      do_op(2'd1, 0, 64'hDEAD_BEEF_3F80_0000, 64'h0, "R6 upper ignored a");
      check("R6 same as clean", out_result, 64'hFFFF_FFFF_BF80_0000);
      do_op(2'd3, 0, 64'h0123_4567_0000_0000, 64'h0, "R6 class upper ignored");
      check("R6 class zero", out_result, 64'h200);
      // classify corners
      do_op(2'd3, 1, 64'hFFF0_0000_0000_0000, 0, "R7 dp -inf");
      do_op(2'd3, 1, 64'h7FF0_0000_0000_0000, 0, "R7 dp +inf");
      do_op(2'd3, 1, 64'h8000_0000_0000_0000, 0, "R7 dp -zero");
      do_op(2'd3, 1, 64'h0000_0000_0000_0001, 0, "R7 dp +sub");
      do_op(2'd3, 1, 64'hFFF8_0000_0000_0000, 0, "R9 dp -qnan");
      do_op(2'd3, 1, 64'h7FF0_0000_0000_0001, 0, "R9 dp +snan");
      do_op(2'd3, 1, 64'hFFF0_0000_0000_0001, 0, "R9 dp -snan");
      do_op(2'd3, 0, 64'h0000_0000_FFC0_0000, 0, "R9 sp -qnan");
      do_op(2'd3, 0, 64'h0000_0000_7F80_0001, 0, "R9 sp +snan");
      do_op(2'd3, 0, 64'h0000_0000_8000_0001, 0, "R7 sp -sub");
      do_op(2'd3, 0, 64'h0000_0000_BF80_0000, 0, "R8 sp -norm");

      // R10: idle with changing inputs holds the result
      do_op(2'd1, 1, 64'h1111_2222_3333_4444, 0, "R3 before hold");
      held = out_result;
      in_fj = 64'hAAAA_5555_AAAA_5555; in_op = 2'd3;
      @(negedge clk);
      check("R10 hold result", out_result, held);
      check("R1 idle valid", {63'd0, out_valid}, 64'd0);

      for (int i = 0; i < 400; i++) begin
         logic [1:0] op = 2'($urandom % 4);
         bit dbl = 1'($urandom % 2);
         do_op(op, dbl, rnd_val(), rnd_val(), tag_of(op, dbl));
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule